// File: doc/BRIEF.md
# DMA Bus Master Arbiter

This block wins and keeps ownership of the host expansion bus on behalf of a SCSI controller that moves data by DMA. When the controller asks for the bus, the block raises its request to the host arbiter. It waits for the grant, then raises an ownership flag and hands the local bus to the controller. It keeps the bus until the controller reports that the transfer has finished. On completion it gives the local bus back in the same clock, and it drops the host request one clock later.

The block also tells the host arbiter when it joins or leaves the set of bus masters. It does this with a single-clock pulse on its request line. The joining pulse is sent once after reset. The leaving pulse is sent when the disable input is raised. Once the block has left, it stays out until the next reset.

Top module: `dma_master_arb`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to its unregistered state: `host_req`, `own_bus` and `dev_grant` are all low.
- R2: After reset is released with `mst_disable` low, `host_req` goes high for exactly one clock. This joining pulse starts in the clock after the first rising edge at which `rst_n` is high. `host_req` then stays low while nothing is requested.
- R3: If `mst_disable` is high when reset is released, the joining pulse is held back and `dev_req` is ignored. The pulse is sent in the clock after `mst_disable` is first seen low.
- R4: In the idle state, a high `dev_req` raises `host_req` from the next clock. `host_req` stays high while `host_grant` is low.
- R5: `own_bus` and `dev_grant` go high together, in the clock after `host_grant` is seen high while requesting. `host_req` is always high while they are high. A grant that arrives while idle is ignored.
- R6: `own_bus` and `dev_grant` go low in the same clock that `xfer_done` is high. `host_req` goes low at the next clock edge.
- R7: After a completion, `host_req` stays low and `dev_req` is ignored for as long as `host_grant` stays high. A new request is accepted only after the grant has been seen low.
- R8: When `mst_disable` is high in the idle state, `host_req` pulses high for exactly one clock. The block then stays unregistered: it ignores `dev_req` and sends no joining pulse, even after `mst_disable` falls, until the next reset.
- R9: When `mst_disable` rises during a request or a transfer, it takes effect only after the transfer completes and the block returns to idle. The leaving pulse then follows one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dev_req | input | 1 | Bus request from the SCSI controller |
| host_grant | input | 1 | Grant from the host bus arbiter |
| xfer_done | input | 1 | The SCSI controller reports that its transfer is complete |
| mst_disable | input | 1 | Withdraws the block from the set of bus masters |
| host_req | output | 1 | Request to the host arbiter; also carries the join and leave pulses |
| own_bus | output | 1 | High while this block owns the host bus |
| dev_grant | output | 1 | Local bus grant to the SCSI controller |

## Verification
The assertions assume a well-behaved environment. The host arbiter grants only while a request is pending. The SCSI controller holds `dev_req` until it is granted. It reports `xfer_done` only while it holds the local bus, or after it has let go of it. The assertions about ownership rising after a grant, and about the request falling after a completion, depend on these rules. The stimulus follows them: it changes inputs only on falling clock edges, raises the grant only after it has seen `host_req` high, and pulses `xfer_done` only during a transfer. One exception is deliberate: the bench applies a grant while the block is idle, to show that the grant is ignored.

// File: rtl/dma_master_pkg.sv
// Package: shared state encoding for the DMA bus master arbiter.
// Assumes: nothing; it holds only types and constants.
package dma_master_pkg;

    localparam int ARB_STATE_W = 3;

    // Sequencer states. The join and leave pulses each have a state of their own.
    typedef enum logic [ARB_STATE_W-1:0] {
        ARB_UNREG    = 3'd0,
        ARB_REGISTER = 3'd1,
        ARB_IDLE     = 3'd2,
        ARB_REQUEST  = 3'd3,
        ARB_OWN      = 3'd4,
        ARB_RELEASE  = 3'd5,
        ARB_DEREG    = 3'd6
    } arb_state_t;

    // Output bundle produced by the decode stage.
    typedef struct packed {
        logic host_req;
        logic own_bus;
        logic dev_grant;
    } arb_drive_t;

endpackage

// File: rtl/dma_master_enroll.sv
// Module: remembers whether the master has left the bus, which retires it
// until reset.
// Assumes: leave_seen is high for the single clock of the leave pulse.
module dma_master_enroll (
    input  logic clk,
    input  logic rst_n,
    input  logic leave_seen,
    output logic retired
);

    // Set the retired flag when the leave pulse is issued; only reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            retired <= 1'b0;
        else if (leave_seen)
            retired <= 1'b1;
    end

endmodule

// File: rtl/dma_master_seq.sv
// Module: state sequencer for joining, requesting, owning, releasing and
// leaving the host bus.
// Assumes: inputs are synchronous to clk; a disable request waits until the
// sequencer is idle.
module dma_master_seq
    import dma_master_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dev_req,
    input  logic       host_grant,
    input  logic       xfer_done,
    input  logic       mst_disable,
    input  logic       retired,
    output arb_state_t state
);

    arb_state_t state_nx;

    // Choose the next state from the current state and the inputs.
    always_comb begin
        state_nx = state;
        unique case (state)
            ARB_UNREG:    if (!retired && !mst_disable) state_nx = ARB_REGISTER;
            ARB_REGISTER: state_nx = ARB_IDLE;
            ARB_IDLE: begin
                if (mst_disable)  state_nx = ARB_DEREG;
                else if (dev_req) state_nx = ARB_REQUEST;
            end
            ARB_REQUEST:  if (host_grant) state_nx = ARB_OWN;
            ARB_OWN:      if (xfer_done)  state_nx = ARB_RELEASE;
            ARB_RELEASE:  if (!host_grant) state_nx = ARB_IDLE;
            ARB_DEREG:    state_nx = ARB_UNREG;
            default:      state_nx = ARB_UNREG;
        endcase
    end

    // Hold the state, returning to unregistered on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ARB_UNREG;
        else
            state <= state_nx;
    end

endmodule

// File: rtl/dma_master_drive.sv
// Module: decodes the sequencer state into the bus-facing outputs.
// Assumes: xfer_done is meaningful only in the owning state; there it cuts
// ownership in the same clock.
module dma_master_drive
    import dma_master_pkg::*;
(
    input  arb_state_t state,
    input  logic       xfer_done,
    output arb_drive_t drv
);

    // Decode the request line, the ownership flag and the local grant.
    always_comb begin
        drv.host_req  = (state == ARB_REGISTER) || (state == ARB_DEREG) ||
                        (state == ARB_REQUEST)  || (state == ARB_OWN);
        drv.own_bus   = (state == ARB_OWN) && !xfer_done;
        drv.dev_grant = (state == ARB_OWN) && !xfer_done;
    end

endmodule

// File: rtl/dma_master_arb.sv
// Module: top of the DMA bus master arbiter. It joins the host bus masters
// after reset, requests and holds the bus for the SCSI controller, and leaves
// on disable.
// Assumes: all inputs are synchronous to clk; reset is synchronous and active low.
module dma_master_arb
    import dma_master_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dev_req,
    input  logic host_grant,
    input  logic xfer_done,
    input  logic mst_disable,
    output logic host_req,
    output logic own_bus,
    output logic dev_grant
);

    arb_state_t state;
    arb_drive_t drv;
    logic       retired;
    logic       leave_seen;

    // Flag the clock in which the leave pulse is issued.
    always_comb leave_seen = (state == ARB_DEREG);

    dma_master_enroll u_enroll (
        .clk        (clk),
        .rst_n      (rst_n),
        .leave_seen (leave_seen),
        .retired    (retired)
    );

    dma_master_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .dev_req     (dev_req),
        .host_grant  (host_grant),
        .xfer_done   (xfer_done),
        .mst_disable (mst_disable),
        .retired     (retired),
        .state       (state)
    );

    dma_master_drive u_drive (
        .state     (state),
        .xfer_done (xfer_done),
        .drv       (drv)
    );

    // Present the decoded bundle on the ports.
    always_comb begin
        host_req  = drv.host_req;
        own_bus   = drv.own_bus;
        dev_grant = drv.dev_grant;
    end

endmodule

// File: rtl/dma_master_arb_chk.sv
// Checker: port-level properties of the DMA bus master arbiter.
// Assumes: the arbiter grants only while a request is pending.
module dma_master_arb_chk (
    input logic clk,
    input logic rst_n,
    input logic host_grant,
    input logic xfer_done,
    input logic host_req,
    input logic own_bus,
    input logic dev_grant
);

    AST_OWN_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        own_bus |-> host_req); // R5

    AST_OWN_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(own_bus) |-> $past(host_grant)); // R5

    AST_LOCAL_FOLLOWS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_grant) |-> own_bus); // R5

    AST_DONE_CUTS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (!own_bus && !dev_grant)); // R6

    AST_REQ_TRAILS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(own_bus) |=> !host_req); // R6

    AST_NO_QUICK_RETAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(own_bus) |=> !own_bus); // R7

endmodule

bind dma_master_arb dma_master_arb_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_grant (host_grant),
    .xfer_done  (xfer_done),
    .host_req   (host_req),
    .own_bus    (own_bus),
    .dev_grant  (dev_grant)
);

// File: tb/sim_dma_master_arb.sv
`timescale 1ns/1ps
module sim_dma_master_arb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dev_req = 1'b0;
    logic host_grant = 1'b0;
    logic xfer_done = 1'b0;
    logic mst_disable = 1'b0;
    logic host_req, own_bus, dev_grant;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dma_master_arb u0 (
        .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .host_grant(host_grant),
        .xfer_done(xfer_done), .mst_disable(mst_disable),
        .host_req(host_req), .own_bus(own_bus), .dev_grant(dev_grant)
    );

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [2:0] exp);
        n_chk++;
        if ({host_req, own_bus, dev_grant} !== exp) begin
            n_bad++;
            $display("FAIL %s: {req,own,gnt} actual=%b expected=%b at %0t",
                     tag, {host_req, own_bus, dev_grant}, exp, $time);
        end
    endtask

    task automatic do_reset(input logic dis);
        rst_n = 1'b0; dev_req = 0; host_grant = 0; xfer_done = 0; mst_disable = dis;
        repeat (3) step();
        chk("R1 reset", 3'b000);
        rst_n = 1'b1;
    endtask

    task automatic t_join();
        do_reset(1'b0);
        step(); chk("R2 join pulse high", 3'b100);
        step(); chk("R2 join pulse ends", 3'b000);
        step(); chk("R2 idle quiet", 3'b000);
    endtask

    task automatic t_idle_grant();
        host_grant = 1;
        step(); chk("R5 idle grant ignored", 3'b000);
        step(); chk("R5 idle grant ignored", 3'b000);
        host_grant = 0;
        step();
    endtask

    task automatic t_transfer();
        dev_req = 1;
        step(); chk("R4 request raised", 3'b100);
        repeat (3) begin step(); chk("R4 request held", 3'b100); end
        host_grant = 1;
        step(); chk("R5 ownership taken", 3'b111);
        step(); chk("R5 ownership held", 3'b111);
        xfer_done = 1; #1;
        chk("R6 done cuts ownership", 3'b100);
        step(); chk("R6 request drops", 3'b000);
        xfer_done = 0;
        repeat (2) begin step(); chk("R7 held off while granted", 3'b000); end
        host_grant = 0;
        step(); chk("R7 back to idle", 3'b000);
        step(); chk("R7 new request", 3'b100);
        host_grant = 1;
        step(); chk("R5 second ownership", 3'b111);
        xfer_done = 1;
        step(); xfer_done = 0; dev_req = 0; host_grant = 0;
        step(); chk("R6 idle again", 3'b000);
    endtask

    task automatic t_deferred_leave();
        dev_req = 1;
        step(); chk("R9 request", 3'b100);
        mst_disable = 1;
        step(); chk("R9 request kept", 3'b100);
        host_grant = 1;
        step(); chk("R9 owned despite disable", 3'b111);
        step(); chk("R9 owned despite disable", 3'b111);
        xfer_done = 1;
        step(); chk("R9 release", 3'b000);
        xfer_done = 0; dev_req = 0; host_grant = 0;
        step(); chk("R9 idle", 3'b000);
        step(); chk("R9 leave pulse", 3'b100);
        step(); chk("R9 leave pulse ends", 3'b000);
        mst_disable = 0; dev_req = 1;
        repeat (3) begin step(); chk("R8 retired ignores request", 3'b000); end
        dev_req = 0;
    endtask

    task automatic t_idle_leave();
        t_join();
        mst_disable = 1;
        step(); chk("R8 leave pulse", 3'b100);
        step(); chk("R8 leave pulse ends", 3'b000);
        mst_disable = 0;
        dev_req = 1;
        repeat (3) begin step(); chk("R8 stays unregistered", 3'b000); end
        dev_req = 0;
    endtask

    task automatic t_held_join();
        do_reset(1'b1);
        step(); chk("R3 join held back", 3'b000);
        dev_req = 1;
        repeat (2) begin step(); chk("R3 request ignored", 3'b000); end
        dev_req = 0; mst_disable = 0;
        step(); chk("R3 late join pulse", 3'b100);
        step(); chk("R3 late join ends", 3'b000);
    endtask

    initial begin
        t_join();
        t_idle_grant();
        t_transfer();
        t_deferred_leave();
        t_idle_leave();
        t_held_join();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule